// File: doc/BRIEF.md
# Serial Frame Field Tracker

This block listens to a serial link and reports which field of the current frame is on the wire. It runs on one free-running system clock. The select and serial-clock lines are treated as ordinary data inputs: each passes through a two-stage synchroniser, and a rising serial-clock edge becomes a one-cycle strobe.

A frame is laid out as follows:

- a single flag bit;
- a short date field, three bits by default;
- a data field, twelve bits by default.

A down-counter is loaded with the last index of each field on the edge that enters that field. The phase advances when the counter has reached zero and another edge arrives. After the last data bit, the tracker goes back to the flag phase, so several frames can be sent within one select window. Dropping select returns it to idle.

Downstream logic uses the phase code and the remaining-bit count to steer serial bits into the right register. It also uses the one-cycle end-of-frame pulse to commit a finished frame.

Top module: `spi_phase_tracker`

## Requirements
- R1: `phase` uses these codes: idle is 2'b11, flag is 2'b00, date is 2'b01 and data is 2'b10.
- R2: In idle with the synchronised select high, the next clock enters the flag phase with `bits_left` at 0.
- R3: A serial-clock rising edge in the flag phase enters the date phase and loads `bits_left` with DATE_BITS-1 (2 by default).
- R4: In the date phase, each edge decrements `bits_left`. An edge that arrives while `bits_left` is 0 enters the data phase and loads DATA_BITS-1 (11 by default).
- R5: In the data phase, each edge decrements `bits_left`. An edge that arrives while `bits_left` is 0 returns to the flag phase, not idle, with `bits_left` at 0.
- R6: `frame_done` is high for exactly the one cycle after the edge that ends the data field, and is low at all other times.
- R7: Without a serial-clock rising edge, the phase and `bits_left` hold their values. A serial clock that stays high produces no further edges.
- R8: While the synchronised select is low, the next clock forces idle with `bits_left` at 0, and serial-clock edges have no effect.
- R9: A synchronous reset (`rst` high) gives idle, `bits_left` 0 and `frame_done` 0.
- R10: Input changes reach the outputs through two synchroniser stages. A serial-clock rise that is set up before clock edge n changes the outputs at edge n+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_in | input | 1 | Link select, transfer active while high (asynchronous) |
| sclk_in | input | 1 | Serial clock, sampled as data (asynchronous) |
| phase | output | 2 | Current frame field code |
| bits_left | output | CNT_W (4) | Bits remaining in the current field, minus one |
| frame_done | output | 1 | One-cycle pulse at the end of each data field |

## Verification
The assertions assume that every input level lasts at least one full system-clock period. Under that assumption, each serial-clock rise yields exactly one strobe, and two strobes can never fall in adjacent cycles. The one-cycle `frame_done` check depends on this. The bench changes inputs only on falling clock edges, in whole-cycle steps, with high and low times of one to four cycles. It never toggles the serial clock faster than the synchroniser can follow, so these assumptions always hold.

// File: rtl/spi_phase_tracker.sv
module spi_phase_tracker #(
  parameter int DATE_BITS = 3,
  parameter int DATA_BITS = 12,
  localparam int CNT_W = $clog2(DATA_BITS > DATE_BITS ? DATA_BITS : DATE_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_in,
  input  logic             sclk_in,
  output logic [1:0]       phase,
  output logic [CNT_W-1:0] bits_left,
  output logic             frame_done
);

  typedef enum logic [1:0] {
    PH_FLAG = 2'b00,
    PH_DATE = 2'b01,
    PH_DATA = 2'b10,
    PH_IDLE = 2'b11
  } phase_t;

  localparam logic [CNT_W-1:0] DATE_LAST = CNT_W'(DATE_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS - 1);

  logic   sel_m, sel_s;
  logic   sck_m, sck_s, sck_p;
  logic   rise;
  phase_t state;
  logic [CNT_W-1:0] cnt;
  logic   done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_m <= 1'b0;
      sel_s <= 1'b0;
      sck_m <= 1'b0;
      sck_s <= 1'b0;
      sck_p <= 1'b0;
    end else begin
      sel_m <= sel_in;
      sel_s <= sel_m;
      sck_m <= sclk_in;
      sck_s <= sck_m;
      sck_p <= sck_s;
    end
  end

  assign rise = sck_s & ~sck_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!sel_s) begin
        state <= PH_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          PH_IDLE: begin
            state <= PH_FLAG;
            cnt   <= '0;
          end
          PH_FLAG: if (rise) begin
            state <= PH_DATE;
            cnt   <= DATE_LAST;
          end
          PH_DATE: if (rise) begin
            if (cnt == '0) begin
              state <= PH_DATA;
              cnt   <= DATA_LAST;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          PH_DATA: if (rise) begin
            if (cnt == '0) begin
              state  <= PH_FLAG;
              done_q <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: begin
            state <= PH_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  assign phase      = state;
  assign bits_left  = cnt;
  assign frame_done = done_q;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> (phase == 2'b11 && bits_left == '0)); // R8

  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00) |-> (bits_left == '0)); // R2

  AST_DATE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b01 && $past(phase) == 2'b00) |-> (bits_left == DATE_LAST)); // R3

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b10 && $past(phase) == 2'b01) |-> (bits_left == DATA_LAST)); // R4

  AST_DONE_TO_FLAG: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (phase == 2'b00 && $past(phase) == 2'b10)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R6

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (sel_s && !rise && phase != 2'b11) |=> ($stable(phase) && $stable(bits_left))); // R7

endmodule

// File: tb/spi_phase_tracker_test.sv
module spi_phase_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATE_N = 3;
  localparam int DATA_N = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_in = 1'b0;
  logic       sclk_in = 1'b0;
  logic [1:0] phase;
  logic [3:0] bits_left;
  logic       frame_done;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int done_seen = 0;
  bit started = 0;

  int m_ph = 3;
  int m_cnt = 0;
  bit m_done = 0;
  bit sel_h[3];
  bit sck_h[3];

  spi_phase_tracker #(.DATE_BITS(DATE_N), .DATA_BITS(DATA_N)) uut (
    .clk(clk), .rst(rst), .sel_in(sel_in), .sclk_in(sclk_in),
    .phase(phase), .bits_left(bits_left), .frame_done(frame_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: input history stands for the two-stage latency (R10)
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 3; m_cnt = 0; m_done = 0;
      for (int i = 0; i < 3; i++) begin sel_h[i] = 0; sck_h[i] = 0; end
    end else begin
      bit s, r;
      s = sel_h[1];
      r = sck_h[1] && !sck_h[2];
      m_done = 0;
      if (!s) begin
        m_ph = 3; m_cnt = 0;
      end else if (m_ph == 3) begin
        m_ph = 0; m_cnt = 0;
      end else if (r) begin
        if (m_ph == 0) begin
          m_ph = 1; m_cnt = DATE_N - 1;
        end else if (m_cnt > 0) begin
          m_cnt--;
        end else if (m_ph == 1) begin
          m_ph = 2; m_cnt = DATA_N - 1;
        end else begin
          m_ph = 0; m_cnt = 0; m_done = 1;
        end
      end
      sel_h[2] = sel_h[1]; sel_h[1] = sel_h[0]; sel_h[0] = sel_in;
      sck_h[2] = sck_h[1]; sck_h[1] = sck_h[0]; sck_h[0] = sclk_in;
    end
    started = 1;
  end

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      vectors++;
      if (phase !== 2'(m_ph)) begin
        fails++;
        $display("FAIL R1 phase code: got %b expected %b at cycle %0d", phase, 2'(m_ph), cycles);
      end
      if (bits_left !== 4'(m_cnt)) begin
        fails++;
        $display("FAIL R4/R5 bits_left: got %0d expected %0d at cycle %0d", bits_left, m_cnt, cycles);
      end
      if (frame_done !== m_done) begin
        fails++;
        $display("FAIL R6 frame_done: got %b expected %b at cycle %0d", frame_done, m_done, cycles);
      end
      if (frame_done === 1'b1) done_seen++;
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); sclk_in = 1'b1;
    repeat (hi - 1) @(negedge clk);
    @(negedge clk); sclk_in = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset phase", {2'b00, phase}, 4'd3);
    check("R9 reset count", bits_left, 4'd0);
    check("R9 reset done", {3'b000, frame_done}, 4'd0);
    rst = 1'b0;
    idle(2);
    sel_in = 1'b1;
    idle(4);
    check("R2 flag entry", {2'b00, phase}, 4'd0);
    // R10: first rise, outputs change at the third edge after setup
    @(negedge clk); sclk_in = 1'b1;
    @(negedge clk); check("R10 latency 1", {2'b00, phase}, 4'd0);
    @(negedge clk); check("R10 latency 2", {2'b00, phase}, 4'd0);
    @(negedge clk); check("R3 date load", bits_left, 4'(DATE_N - 1));
    check("R3 date phase", {2'b00, phase}, 4'd1);
    idle(6);
    check("R7 held high no edge", bits_left, 4'(DATE_N - 1));
    sclk_in = 1'b0; idle(2);
    for (int i = 0; i < DATE_N; i++) pulse(2, 2);
    idle(2);
    check("R4 data load", bits_left, 4'(DATA_N - 1));
    for (int i = 0; i < DATA_N; i++) pulse(1 + (i % 3), 1 + (i % 2));
    idle(3);
    check("R5 back to flag", {2'b00, phase}, 4'd0);
    check("R6 one pulse", 4'(done_seen), 4'd1);
    // second frame straight after, fast edges
    for (int i = 0; i < 1 + DATE_N + DATA_N; i++) pulse(1, 1);
    idle(4);
    check("R6 second frame done", 4'(done_seen), 4'd2);
    // partial frame then deselect
    for (int i = 0; i < 6; i++) pulse(2, 1);
    sel_in = 1'b0;
    idle(4);
    check("R8 deselect idle", {2'b00, phase}, 4'd3);
    for (int i = 0; i < 5; i++) pulse(1, 2);
    idle(3);
    check("R8 edges ignored", bits_left, 4'd0);
    check("R8 still idle", {2'b00, phase}, 4'd3);
    sel_in = 1'b1;
    idle(4);
    for (int i = 0; i < 1 + DATE_N + DATA_N; i++) pulse(3, 4);
    idle(4);
    check("R6 third frame done", 4'(done_seen), 4'd3);
    rst = 1'b1; idle(2);
    check("R9 mid-run reset", {2'b00, phase}, 4'd3);
    rst = 1'b0; sel_in = 1'b0; idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule